// File: doc/BRIEF.md
# Host Register Port with Odd Parity and Interrupt Flags

This block is a slave port through which a host microprocessor reaches a bank of 32 eight-bit registers. The host runs an asynchronous handshake. It drives a 5-bit address, a read/write select and, for writes, eight data bits plus one parity bit. It then pulls an active-low select. The port passes the select and the read/write line through a synchroniser into its own clock. It performs exactly one register access for each falling edge of the select. It then answers with an active-low acknowledge and holds that level until the host releases the select.

On a write, an odd-parity check guards the data whenever the host's check-enable input is high. A write that fails the check changes no register and raises a parity-error flag. On a read, the port always returns odd parity along with the data. It drives both only while acknowledge is low, and it signals this through a separate output-enable.

Two of the 32 addresses hold a sticky interrupt-flag register and its enable mask. Seven event inputs from the surrounding logic, plus the parity-error flag, set bits in the flag register. The host clears a flag by writing 1 to it. An active-low interrupt output is asserted whenever a set flag has its mask bit enabled.

Top module: `hbus_slave`

## Requirements
- R1: After reset, hostAckN and hostIrqN are high, hostDataOe is low, and every register (general, flag at address 30, mask at address 31) reads 0x00.
- R2: A cycle starts when hostSelN is first sampled low on a rising clock edge. hostAckN stays high through the third rising edge counted from that one and is low after the fourth. With hostRdWr=0, the register at hostAddr takes hostDataIn on that cycle.
- R3: Once low, hostAckN stays low while hostSelN stays low. It returns high after the third rising edge that samples hostSelN high, and not before.
- R4: Only one register access is made per falling edge of hostSelN. A change on hostDataIn after acknowledge, while hostSelN is still low, does not alter the register.
- R5: With hostRdWr=1, hostDataOut carries the addressed register's value and hostDataOe is high exactly while hostAckN is low. The value is stable during that time. In a write cycle hostDataOe stays low.
- R6: During a read, hostDataOut and hostParOut together hold an odd number of ones, whatever the level of hostParChkEn.
- R7: With hostParChkEn=1, a write whose nine bits {hostDataIn, hostParIn} hold an even number of ones leaves the target register unchanged and sets flag bit 7 (parity error).
- R8: With hostParChkEn=0, a write with wrong parity is stored normally and sets no flag.
- R9: A one-clock pulse on evtIn[i] (i = 0..6) sets flag bit i. The bit stays set until the host clears it.
- R10: Writing the flag register (address 30) clears each bit written as 1 and leaves bits written as 0. An event arriving on the clock of the clearing write keeps its bit set.
- R11: hostIrqN is low exactly when some flag bit is set and the same bit of the mask register (address 31, 1 = enabled) is set.
- R12: Writes to address 30 only clear flags and never store the data. Addresses 0 to 29 are independent storage, and address 31 holds the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSelN | input | 1 | Host select, active low, asynchronous |
| hostRdWr | input | 1 | 1 = read cycle, 0 = write cycle |
| hostAddr | input | 5 | Register address |
| hostDataIn | input | 8 | Write data from the host |
| hostParIn | input | 1 | Odd-parity bit for hostDataIn |
| hostParChkEn | input | 1 | 1 = check parity on writes |
| evtIn | input | 7 | Single-clock event pulses that set flag bits 0..6 |
| hostDataOut | output | 8 | Read data toward the host |
| hostParOut | output | 1 | Odd-parity bit for hostDataOut |
| hostDataOe | output | 1 | Drive enable for hostDataOut and hostParOut |
| hostAckN | output | 1 | Acknowledge, active low |
| hostIrqN | output | 1 | Interrupt, active low |

## Verification
The assertions check the handshake on every cycle. Acknowledge may fall only after a select low seen four samples earlier, and may rise only after a select high seen three samples earlier. It holds while the select stays low. The read enable is tied to acknowledge, read data holds steady, and read parity is odd. An asserted interrupt also cannot drop while no host access is pending. Whether data reaches the right register, whether a parity failure suppresses the write and sets its flag, the priority of an event over a clear, and the mask gating can be shown only by the bench's directed write and readback sequences.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // Strobes from the handshake control to the datapath
  typedef struct packed {
    logic commitWr;  // one clock: perform the register write
    logic commitRd;  // one clock: capture read data
    logic ackOn;     // acknowledge phase
    logic rdPhase;   // acknowledge phase of a read cycle
  } busStrobe_t;

endpackage

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSelN,
  input  logic       hostRdWr,
  output busStrobe_t strobe
);

  logic [SYNC_STAGES-1:0] selPipe;
  logic [SYNC_STAGES-1:0] rwPipe;
  logic selSyncN;
  logic rwSync;

  // Synchroniser chain; resets to the idle (high) level
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selPipe[i] <= 1'b1;
          rwPipe[i]  <= 1'b1;
        end else begin
          selPipe[i] <= hostSelN;
          rwPipe[i]  <= hostRdWr;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selPipe[i] <= 1'b1;
          rwPipe[i]  <= 1'b1;
        end else begin
          selPipe[i] <= selPipe[i-1];
          rwPipe[i]  <= rwPipe[i-1];
        end
      end
    end
  end

  assign selSyncN = selPipe[SYNC_STAGES-1];
  assign rwSync   = rwPipe[SYNC_STAGES-1];

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMMIT = 2'd1,
    ST_HOLD   = 2'd2
  } cycState_t;

  cycState_t stateQ;
  logic      isReadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      isReadQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (!selSyncN) begin
            stateQ  <= ST_COMMIT;
            isReadQ <= rwSync;
          end
        end
        ST_COMMIT: stateQ <= ST_HOLD;
        ST_HOLD: begin
          if (selSyncN) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.commitWr = (stateQ == ST_COMMIT) && !isReadQ;
    strobe.commitRd = (stateQ == ST_COMMIT) && isReadQ;
    strobe.ackOn    = (stateQ == ST_HOLD);
    strobe.rdPhase  = (stateQ == ST_HOLD) && isReadQ;
  end

endmodule

// File: rtl/hbus_dpath.sv
module hbus_dpath
  import hbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic              hostParIn,
  input  logic              hostParChkEn,
  input  logic [DATA_W-2:0] evtIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostParOut,
  output logic              hostDataOe,
  output logic              irqActive
);

  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int FLAG_ADDR = NUM_REGS - 2;
  localparam int MASK_ADDR = NUM_REGS - 1;
  localparam int NUM_EVT   = DATA_W - 1;
  localparam int PERR_BIT  = DATA_W - 1;

  logic parOk;
  logic wrAccept;
  logic parErr;

  // Odd parity over nine bits: total ones must be odd
  assign parOk    = ^{hostDataIn, hostParIn};
  assign wrAccept = strobe.commitWr && (!hostParChkEn || parOk);
  assign parErr   = strobe.commitWr && hostParChkEn && !parOk;

  logic [NUM_REGS-1:0][DATA_W-1:0] regView;
  logic [DATA_W-1:0] flagQ;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] flagSet;
  logic [DATA_W-1:0] flagClr;

  always_comb begin
    flagSet                = '0;
    flagSet[NUM_EVT-1:0]   = evtIn;
    flagSet[PERR_BIT]      = parErr;
    flagClr = (wrAccept && (hostAddr == ADDR_W'(FLAG_ADDR))) ? hostDataIn : '0;
  end

  // Sticky flags: a new event wins over a clear in the same clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~flagClr) | flagSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else if (wrAccept && (hostAddr == ADDR_W'(MASK_ADDR))) maskQ <= hostDataIn;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == FLAG_ADDR) begin : g_flag
      assign regView[g] = flagQ;
    end else if (g == MASK_ADDR) begin : g_mask
      assign regView[g] = maskQ;
    end else begin : g_store
      logic [DATA_W-1:0] cellQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cellQ <= '0;
        else if (wrAccept && (hostAddr == ADDR_W'(g))) cellQ <= hostDataIn;
      end
      assign regView[g] = cellQ;
    end
  end

  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (strobe.commitRd) rdQ <= regView[hostAddr];
  end

  assign hostDataOut = rdQ;
  assign hostParOut  = ~^rdQ;
  assign hostDataOe  = strobe.rdPhase;
  assign irqActive   = |(flagQ & maskQ);

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSelN,
  input  logic              hostRdWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic              hostParIn,
  input  logic              hostParChkEn,
  input  logic [DATA_W-2:0] evtIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostParOut,
  output logic              hostDataOe,
  output logic              hostAckN,
  output logic              hostIrqN
);

  hbus_pkg::busStrobe_t strobe;
  logic irqActive;

  hbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSelN (hostSelN),
    .hostRdWr (hostRdWr),
    .strobe   (strobe)
  );

  hbus_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .hostAddr     (hostAddr),
    .hostDataIn   (hostDataIn),
    .hostParIn    (hostParIn),
    .hostParChkEn (hostParChkEn),
    .evtIn        (evtIn),
    .hostDataOut  (hostDataOut),
    .hostParOut   (hostParOut),
    .hostDataOe   (hostDataOe),
    .irqActive    (irqActive)
  );

  assign hostAckN = !strobe.ackOn;
  assign hostIrqN = !irqActive;

endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostSelN,
  input logic              hostAckN,
  input logic              hostDataOe,
  input logic [DATA_W-1:0] hostDataOut,
  input logic              hostParOut,
  input logic              hostIrqN
);

  // Acknowledge falls only after select was seen low four samples back
  assert_ack_after_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostAckN) |-> !$past(hostSelN, 4));

  // Acknowledge rises only after select was seen high three samples back
  assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAckN) |-> $past(hostSelN, 3));

  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!hostAckN && !hostSelN && !$past(hostSelN) && !$past(hostSelN, 2)) |=> !hostAckN);

  assert_oe_in_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> !hostAckN);

  assert_rd_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostDataOe && $past(hostDataOe)) |-> $stable(hostDataOut));

  assert_rd_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> (^{hostDataOut, hostParOut}));

  // With no host access pending, an asserted interrupt cannot drop
  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!hostIrqN && hostSelN && $past(hostSelN) && $past(hostSelN, 2) && $past(hostSelN, 3))
      |=> !hostIrqN);

endmodule

bind hbus_slave hbus_slave_chk #(.DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .hostSelN    (hostSelN),
  .hostAckN    (hostAckN),
  .hostDataOe  (hostDataOe),
  .hostDataOut (hostDataOut),
  .hostParOut  (hostParOut),
  .hostIrqN    (hostIrqN)
);

// File: tb/sim_hbus_slave.sv
`timescale 1ns/1ps
module sim_hbus_slave;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSelN = 1'b1;
  logic       hostRdWr = 1'b1;
  logic [4:0] hostAddr = '0;
  logic [7:0] hostDataIn = '0;
  logic       hostParIn = 1'b1;
  logic       hostParChkEn = 1'b1;
  logic [6:0] evtIn = '0;
  logic [7:0] hostDataOut;
  logic       hostParOut;
  logic       hostDataOe;
  logic       hostAckN;
  logic       hostIrqN;

  int nVec = 0;
  int nBad = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hbus_slave u0 (
    .clk(clk), .rstN(rstN), .hostSelN(hostSelN), .hostRdWr(hostRdWr),
    .hostAddr(hostAddr), .hostDataIn(hostDataIn), .hostParIn(hostParIn),
    .hostParChkEn(hostParChkEn), .evtIn(evtIn), .hostDataOut(hostDataOut),
    .hostParOut(hostParOut), .hostDataOe(hostDataOe), .hostAckN(hostAckN),
    .hostIrqN(hostIrqN)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One full handshake; checks timing of acknowledge and the read outputs
  task automatic busCycle(input bit rd, input logic [4:0] a, input logic [7:0] d,
                          input bit badPar, input bit chkEn, input logic [6:0] evtAtCommit,
                          input logic [7:0] midData, output logic [7:0] rdData);
    logic [7:0] firstRd;
    rdData = '0;
    @(negedge clk);
    hostAddr = a; hostRdWr = rd; hostDataIn = d;
    hostParIn = (~^d) ^ badPar; hostParChkEn = chkEn;
    hostSelN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hostAckN == 1'b1, "R2 ack still high after third edge", hostAckN, 1);
    evtIn = evtAtCommit;
    @(posedge clk);
    @(negedge clk);
    evtIn = '0;
    chk(hostAckN == 1'b0, "R2 ack low after fourth edge", hostAckN, 0);
    if (rd) begin
      chk(hostDataOe == 1'b1, "R5 read enable during ack", hostDataOe, 1);
      rdData = hostDataOut;
      chk(^{hostDataOut, hostParOut} == 1'b1, "R6 read parity odd",
          {hostParOut, hostDataOut}, {~^hostDataOut, hostDataOut});
    end else begin
      chk(hostDataOe == 1'b0, "R5 no read enable in write", hostDataOe, 0);
    end
    firstRd = hostDataOut;
    hostDataIn = midData; hostParIn = ~^midData;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(hostAckN == 1'b0, "R3 ack held while select low", hostAckN, 0);
    if (rd) chk(hostDataOut == firstRd, "R5 read data stable", hostDataOut, firstRd);
    hostSelN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(hostAckN == 1'b0, "R3 ack not released early", hostAckN, 0);
    @(posedge clk);
    @(negedge clk);
    chk(hostAckN == 1'b1, "R3 ack released", hostAckN, 1);
    chk(hostDataOe == 1'b0, "R5 enable drops with ack", hostDataOe, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic hostWr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] unused;
    busCycle(1'b0, a, d, 1'b0, 1'b1, 7'h0, d, unused);
  endtask

  task automatic hostRd(input logic [4:0] a, output logic [7:0] d);
    busCycle(1'b1, a, 8'h00, 1'b0, 1'b1, 7'h0, 8'h00, d);
  endtask

  task automatic expectRd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    hostRd(a, got);
    chk(got == exp, tag, got, exp);
  endtask

  task automatic testReset();
    chk(hostAckN == 1'b1, "R1 ack high after reset", hostAckN, 1);
    chk(hostIrqN == 1'b1, "R1 irq high after reset", hostIrqN, 1);
    chk(hostDataOe == 1'b0, "R1 enable low after reset", hostDataOe, 0);
    expectRd(5'd5, 8'h00, "R1 general register zero");
    expectRd(5'd30, 8'h00, "R1 flag register zero");
    expectRd(5'd31, 8'h00, "R1 mask register zero");
  endtask

  task automatic testWriteRead();
    hostWr(5'd3, 8'h5A);
    hostWr(5'd29, 8'hFF);
    hostWr(5'd0, 8'h81);
    hostWr(5'd30, 8'hFF);
    expectRd(5'd3, 8'h5A, "R2 readback addr 3");
    expectRd(5'd29, 8'hFF, "R5 readback addr 29");
    expectRd(5'd0, 8'h81, "R12 readback addr 0");
    expectRd(5'd30, 8'h00, "R12 flag register not stored");
    expectRd(5'd31, 8'h00, "R12 mask untouched by other writes");
  endtask

  task automatic testSingleCommit();
    logic [7:0] unused;
    busCycle(1'b0, 5'd7, 8'h11, 1'b0, 1'b1, 7'h0, 8'h22, unused);
    expectRd(5'd7, 8'h11, "R4 one write per select edge");
  endtask

  task automatic testParity();
    logic [7:0] unused;
    logic [7:0] got;
    busCycle(1'b0, 5'd8, 8'h33, 1'b1, 1'b1, 7'h0, 8'h33, unused);
    expectRd(5'd8, 8'h00, "R7 bad parity write suppressed");
    expectRd(5'd30, 8'h80, "R7 parity error flag set");
    hostWr(5'd30, 8'h80);
    busCycle(1'b0, 5'd9, 8'h44, 1'b1, 1'b0, 7'h0, 8'h44, unused);
    expectRd(5'd9, 8'h44, "R8 unchecked write stored");
    expectRd(5'd30, 8'h00, "R8 no flag when unchecked");
    // read parity with checking disabled
    busCycle(1'b1, 5'd9, 8'h00, 1'b0, 1'b0, 7'h0, 8'h00, got);
    chk(got == 8'h44, "R6 read with check disabled", got, 8'h44);
  endtask

  task automatic testFlags();
    logic [7:0] unused;
    @(negedge clk); evtIn = 7'h04;
    @(negedge clk); evtIn = 7'h00;
    repeat (3) @(negedge clk);
    chk(hostIrqN == 1'b1, "R11 masked flag keeps irq high", hostIrqN, 1);
    expectRd(5'd30, 8'h04, "R9 event sets sticky flag");
    hostWr(5'd31, 8'h04);
    chk(hostIrqN == 1'b0, "R11 enabled flag drives irq", hostIrqN, 0);
    hostWr(5'd30, 8'h00);
    expectRd(5'd30, 8'h04, "R10 writing zero keeps flag");
    busCycle(1'b0, 5'd30, 8'h04, 1'b0, 1'b1, 7'h04, 8'h04, unused);
    expectRd(5'd30, 8'h04, "R10 event wins over clear");
    chk(hostIrqN == 1'b0, "R11 irq stays with flag", hostIrqN, 0);
    hostWr(5'd30, 8'h04);
    expectRd(5'd30, 8'h00, "R10 write one clears flag");
    chk(hostIrqN == 1'b1, "R11 irq released after clear", hostIrqN, 1);
    // parity error flag through the mask
    busCycle(1'b0, 5'd12, 8'h0F, 1'b1, 1'b1, 7'h0, 8'h0F, unused);
    chk(hostIrqN == 1'b1, "R11 parity flag masked", hostIrqN, 1);
    hostWr(5'd31, 8'h80);
    chk(hostIrqN == 1'b0, "R11 parity flag enabled", hostIrqN, 0);
    expectRd(5'd31, 8'h80, "R12 mask readback");
    hostWr(5'd30, 8'hFF);
    chk(hostIrqN == 1'b1, "R10 clear all flags", hostIrqN, 1);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWriteRead();
    testSingleCommit();
    testParity();
    testFlags();
    doneFlag = 1'b1;
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!doneFlag) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      report();
    end
  end

endmodule